// File: doc/BRIEF.md
# Glitch-Free Transmit/Receive Clock Selector

This block picks which of two slow clocks drives the shared bit-rate clock of a half-duplex serial engine. One source is the bit clock recovered from incoming data, the other is the locally divided transmit bit clock. Logic that lives across both phases of a transaction, such as a CRC generator, runs from the single selected clock.

A four-state handover machine runs on the fast oversampling clock. Both source clocks pass through a register stage on that fast clock, and the machine reads only those sampled levels.

The machine leaves the active source only while that source is low. It then holds the output low for at least one fast cycle. It takes up the new source only once that source is also low. The output is therefore never truncated and never carries a runt pulse, and its low period stretches at each phase change. A mode flag chooses the wanted source. The flag is assumed to be synchronous to the fast clock.

Top module: `glitchless_clk_sel`

## Requirements
- R1: A synchronous active-low reset puts the selector in the transmit state, drives `clk_out` to 0 and `src_sel` to 2'b10.
- R2: In the receive state, `clk_out` repeats the level of `rx_clk` two fast-clock edges later.
- R3: In the transmit state, `clk_out` repeats the level of `tx_clk` two fast-clock edges later.
- R4: The receive state is left only when `rx_mode` is low and the sampled `rx_clk` level is low. The next state is the receive-to-transmit handover state.
- R5: The receive-to-transmit handover state moves to the transmit state when the sampled `tx_clk` level is low.
- R6: The transmit state is left only when `rx_mode` is high and the sampled `tx_clk` level is low. The next state is the transmit-to-receive handover state.
- R7: The transmit-to-receive handover state moves to the receive state when the sampled `rx_clk` level is low.
- R8: In both handover states `clk_out` is 0. A handover that has started always completes, whatever `rx_mode` does meanwhile. There is never a direct step between the receive and transmit states.
- R9: `src_sel` reports the source driving `clk_out` with this encoding: 2'b01 for receive, 2'b10 for transmit, 2'b00 for handover.
- R10: When each source clock has a high phase of two fast cycles, every high pulse on `clk_out` is exactly two fast cycles long, including pulses next to a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oversampling clock that runs the selector |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_mode | input | 1 | High requests the recovered receive clock, low requests the transmit clock |
| rx_clk | input | 1 | Recovered receive bit clock |
| tx_clk | input | 1 | Divided transmit bit clock |
| clk_out | output | 1 | Selected, glitch-free bit clock |
| src_sel | output | 2 | Current source: 01 receive, 10 transmit, 00 handover |

## Verification
A wrong state or transition in this block shows at the ports within two fast cycles. It appears as a `src_sel` code that disagrees with the reference, or as a `clk_out` level copied from the wrong source. A transition taken while a source is high would cut a high pulse short. The pulse-width check catches that on the next falling edge of `clk_out`. A handover that skips its dead state, or is abandoned partway, shows as a missing 2'b00 cycle on `src_sel` in the cycle the reference expects it.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the glitch-free clock selector.
// Assumes: state codes are internal; only src_sel codes are visible at ports.
package gcs_pkg;
    typedef enum logic [1:0] {
        ST_RX    = 2'd0,
        ST_TO_TX = 2'd1,
        ST_TO_RX = 2'd2,
        ST_TX    = 2'd3
    } gcs_state_e;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_RX   = 2'b01;
    localparam logic [1:0] SEL_TX   = 2'b10;
endpackage

// File: rtl/level_sampler.sv
`timescale 1ns/1ps
// Module: level_sampler
// Samples WIDTH asynchronous clock levels through STAGES registers on the
// fast clock. Assumes the consumer tolerates STAGES cycles of latency.
module level_sampler #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] lvl_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture raw levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= lvl_in;
                end
            end else begin : g_next
                // shift sampled levels one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign lvl_out = chain_q[STAGES-1];
endmodule

// File: rtl/handover_fsm.sv
`timescale 1ns/1ps
// Module: handover_fsm
// Four-state source handover: leaves a source only while it is low, rests in
// a dead-low state, and takes up the new source only while that one is low.
// Assumes rx_mode is synchronous to clk and levels come pre-sampled.
module handover_fsm
    import gcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_mode,
    input  logic       rx_lvl,
    input  logic       tx_lvl,
    output gcs_state_e state_q,
    output gcs_state_e state_nx
);
    // next-state decision from sampled levels and the mode flag
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RX:    if (!rx_mode && !rx_lvl) state_nx = ST_TO_TX;
            ST_TO_TX: if (!tx_lvl)             state_nx = ST_TX;
            ST_TX:    if (rx_mode && !tx_lvl)  state_nx = ST_TO_RX;
            ST_TO_RX: if (!rx_lvl)             state_nx = ST_RX;
            default:                           state_nx = ST_TX;
        endcase
    end

    // state register, reset lands on the transmit source
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TX;
        else        state_q <= state_nx;
    end

    // R4
    rx_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RX && state_q != ST_RX) |-> ($past(!rx_mode) && $past(!rx_lvl)));
    // R6
    tx_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TX && state_q != ST_TX) |-> ($past(rx_mode) && $past(!tx_lvl)));
    // R5
    tx_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TO_TX && state_q == ST_TX) |-> $past(!tx_lvl));
    // R7
    rx_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TO_RX && state_q == ST_RX) |-> $past(!rx_lvl));
    // R8
    no_rx_to_tx_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX) |=> (state_q != ST_TX));
    // R8
    no_tx_to_rx_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX) |=> (state_q != ST_RX));
endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
// Module: out_stage
// Registers the selected clock and the source code from the next state, so
// the output changes only on the fast clock edge and never glitches.
// Assumes state_nx only enters a source state while that source is low.
module out_stage
    import gcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gcs_state_e state_nx,
    input  logic       rx_lvl,
    input  logic       tx_lvl,
    output logic       clk_out,
    output logic [1:0] src_sel
);
    logic       out_d;
    logic [1:0] sel_d;

    // pick the output level and code for the coming state
    always_comb begin
        unique case (state_nx)
            ST_RX:   begin out_d = rx_lvl; sel_d = SEL_RX;   end
            ST_TX:   begin out_d = tx_lvl; sel_d = SEL_TX;   end
            default: begin out_d = 1'b0;   sel_d = SEL_NONE; end
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_out <= 1'b0;
            src_sel <= SEL_TX;
        end else begin
            clk_out <= out_d;
            src_sel <= sel_d;
        end
    end

    // R8
    dead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SEL_NONE) |-> !clk_out);
    // R9
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel));
endmodule

// File: rtl/glitchless_clk_sel.sv
`timescale 1ns/1ps
// Module: glitchless_clk_sel (top)
// Selects the receive or transmit bit clock for shared half-duplex logic,
// switching only through a dead-low handover. Assumes both sources are much
// slower than clk_fast and rx_mode is synchronous to clk_fast.
module glitchless_clk_sel
    import gcs_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic       clk_fast,
    input  logic       rst_n,
    input  logic       rx_mode,
    input  logic       rx_clk,
    input  logic       tx_clk,
    output logic       clk_out,
    output logic [1:0] src_sel
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0] lvl_s;
    gcs_state_e         state_q;
    gcs_state_e         state_nx;

    level_sampler #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sampler_i (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .lvl_in  ({tx_clk, rx_clk}),
        .lvl_out (lvl_s)
    );

    handover_fsm fsm_i (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .rx_mode  (rx_mode),
        .rx_lvl   (lvl_s[0]),
        .tx_lvl   (lvl_s[1]),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    out_stage out_i (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .state_nx (state_nx),
        .rx_lvl   (lvl_s[0]),
        .tx_lvl   (lvl_s[1]),
        .clk_out  (clk_out),
        .src_sel  (src_sel)
    );

    // R8
    handover_commit_tx_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_TO_TX) |=> (state_q == ST_TO_TX || state_q == ST_TX));
    // R8
    handover_commit_rx_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_TO_RX) |=> (state_q == ST_TO_RX || state_q == ST_RX));
    // R9
    sel_tracks_state_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_RX) |-> (src_sel == SEL_RX));
endmodule

// File: tb/glitchless_clk_sel_tb.sv
`timescale 1ns/1ps
module glitchless_clk_sel_tb_top;
    logic       clk_fast = 1'b0;
    logic       rst_n    = 1'b0;
    logic       rx_mode  = 1'b0;
    logic       rx_clk   = 1'b0;
    logic       tx_clk   = 1'b0;
    logic       clk_out;
    logic [1:0] src_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state: 0 rx, 1 to-tx, 2 to-rx, 3 tx
    int m_st = 3, m_out = 0, m_sel = 2, m_rs = 0, m_ts = 0;
    int n_r2h = 0, n_h2t = 0, n_t2h = 0, n_h2r = 0, n_flip = 0;
    int tx_ph = 0, rx_cnt = 0, rx_low = 2, mode_cnt = 20;
    int hi_run = 0;

    always #2.5 clk_fast = ~clk_fast;

    glitchless_clk_sel dut_i (
        .clk_fast (clk_fast), .rst_n (rst_n), .rx_mode (rx_mode),
        .rx_clk (rx_clk), .tx_clk (tx_clk), .clk_out (clk_out), .src_sel (src_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the reference by one edge using inputs present at that edge
    task automatic model_step();
        int nx;
        string tag;
        if (!rst_n) begin
            m_st = 3; m_out = 0; m_sel = 2; m_rs = 0; m_ts = 0;
            return;
        end
        nx = m_st;
        tag = "";
        case (m_st)
            0: if (!rx_mode && m_rs == 0) begin nx = 1; n_r2h++; tag = "R4"; end
            1: if (m_ts == 0) begin nx = 3; n_h2t++; tag = "R5"; end
            3: if (rx_mode && m_ts == 0) begin nx = 2; n_t2h++; tag = "R6"; end
            2: if (m_rs == 0) begin nx = 0; n_h2r++; tag = "R7"; end
            default: nx = 3;
        endcase
        if ((m_st == 1 && rx_mode) || (m_st == 2 && !rx_mode)) n_flip++;
        m_out = (nx == 0) ? m_rs : (nx == 3) ? m_ts : 0;
        m_sel = (nx == 0) ? 1 : (nx == 3) ? 2 : 0;
        m_st = nx;
        m_rs = rx_clk;
        m_ts = tx_clk;
    endtask

    // one fast cycle: update model, compare, then drive next inputs
    task automatic step(input bit run);
        string tg;
        @(negedge clk_fast);
        model_step();
        if (rst_n) begin
            tg = (m_st == 0) ? "R2" : (m_st == 3) ? "R3" : "R8";
            check(tg, clk_out, m_out);
            check("R9", src_sel, m_sel);
            if (clk_out) hi_run++;
            else begin
                if (hi_run != 0) check("R10", hi_run, 2);
                hi_run = 0;
            end
        end
        if (run) begin
            tx_ph = (tx_ph + 1) % 4;
            tx_clk = (tx_ph >= 2);
            rx_cnt++;
            if (rx_cnt >= 2 + rx_low) begin
                rx_cnt = 0;
                rx_low = $urandom_range(1, 3);
            end
            rx_clk = (rx_cnt < 2);
            mode_cnt--;
            if (mode_cnt <= 0) begin
                rx_mode = ~rx_mode;
                mode_cnt = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3)
                                                       : $urandom_range(4, 40);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step(0);
        // R1: reset state
        check("R1", clk_out, 0);
        check("R1", src_sel, 2);
        @(negedge clk_fast);
        rst_n = 1'b1;
        for (int i = 0; i < 6000; i++) step(1);
        // mid-run reset
        rst_n = 1'b0;
        step(0);
        step(0);
        check("R1", clk_out, 0);
        check("R1", src_sel, 2);
        rst_n = 1'b1;
        hi_run = 0;
        for (int i = 0; i < 2000; i++) step(1);
        check("R4", (n_r2h > 0) ? 1 : 0, 1);
        check("R5", (n_h2t > 0) ? 1 : 0, 1);
        check("R6", (n_t2h > 0) ? 1 : 0, 1);
        check("R7", (n_h2r > 0) ? 1 : 0, 1);
        check("R8", (n_flip > 0) ? 1 : 0, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule